// File: doc/BRIEF.md
# Dual-Strobe Up/Down Cascadable Counter

A four-bit synchronous counter whose modulus is fixed at elaboration: ten for decimal digit counting or sixteen for plain binary counting. It is stepped by two independent strobes that idle high. A rising edge on the up strobe advances the count, and a rising edge on the down strobe moves it back. Both strobes are sampled in the system clock domain through two-flop synchronizers, and the counter acts on the detected edges. The strobes are never used as clocks.

An active-low load copies a parallel preset word into the counter. An active-high clear forces the count to zero at once, without waiting for a clock edge, and it overrides every other input. Each direction has its own active-low terminal flag. The carry flag is low while the count sits at its top value and the up strobe is low. The borrow flag is low while the count is zero and the down strobe is low. When the strobe returns high, the flag rises, and that rising edge can act as the next stage's strobe. Wide counters are therefore built by chaining stages flag-to-strobe with no other logic.

Top module: `dual_strobe_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the count is 0 and both carry_n and borrow_n are high until a strobe acts.
- R2: Each rising edge of up_stb raises the count by one. The new value appears no later than the third clock edge after the strobe rises. A strobe held steady at either level causes no change.
- R3: Each rising edge of dn_stb lowers the count by one.
- R4: Counting up from the top value (9 with MODULUS=10, 15 with MODULUS=16) gives 0. Counting down from 0 gives the top value.
- R5: While load_n is low at a clock edge, the count takes the value of preset. Load wins over both strobes.
- R6: While clear is high, the count is 0 with no clock edge needed. Clear overrides load, preset and both strobes.
- R7: carry_n is low exactly when the count equals the top value and the synchronized up strobe is low.
- R8: borrow_n is low exactly when the count is 0 and the synchronized down strobe is low.
- R9: If both strobes show a rising edge in the same clock cycle, the count holds.
- R10: With MODULUS=10, a preset of 10 to 15 counts up by one per edge and wraps from 15 to 0. carry_n stays high at those values.
- R11: When one stage's carry_n drives the next stage's up strobe and its borrow_n drives the next stage's down strobe, the pair counts as a two-digit counter in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_stb | input | 1 | Up strobe, idle high, counts on rising edge |
| dn_stb | input | 1 | Down strobe, idle high, counts on rising edge |
| load_n | input | 1 | Active-low parallel load |
| clear | input | 1 | Active-high asynchronous clear of the count |
| preset | input | WIDTH | Parallel preset value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low up terminal flag |
| borrow_n | output | 1 | Active-low down terminal flag |

## Verification
The assertions take four things for granted about the inputs. The strobes stay at each level for at least two clock cycles. Load is not asserted during the two-cycle reset release window. A clear pulse is never shorter than one clock period. Only one strobe moves at a time, except when same-cycle edges are being tested on purpose. The directed stimulus meets all four: it changes inputs on falling clock edges, holds every strobe level for four or more cycles, and asserts clear and load only once reset has fully settled.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2,
    ACT_LOAD = 2'd3
  } act_e;
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/dsc_strobe_edge.sv
module dsc_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic level_o,
  output logic rise_o
);
  // synchronizer and previous-level flops reset to the idle-high level
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], strobe_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dsc_count_core.sv
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             up_rise,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  act_e             act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] dec_val;
  logic             cnt_en;

  // increment: a full-range modulus wraps by width alone
  generate
    if (MODULUS == (1 << WIDTH)) begin : g_full_inc
      assign inc_val = cnt_q + ONE;
    end else begin : g_short_inc
      assign inc_val = (cnt_q == TOP) ? '0 : cnt_q + ONE;
    end
  endgenerate

  assign dec_val = (cnt_q == '0) ? TOP : cnt_q - ONE;

  always_comb begin
    if (!load_n)                 act = ACT_LOAD;
    else if (up_rise && !dn_rise) act = ACT_UP;
    else if (dn_rise && !up_rise) act = ACT_DOWN;
    else                          act = ACT_HOLD;
  end

  always_comb begin
    cnt_en = (act != ACT_HOLD);
    unique case (act)
      ACT_LOAD: cnt_d = preset;
      ACT_UP:   cnt_d = inc_val;
      ACT_DOWN: cnt_d = dec_val;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n or posedge clear) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dsc_tc_flags.sv
module dsc_tc_flags #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_level,
  input  logic             dn_level,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);

  assign carry_n  = ~((count == TOP) & ~up_level);
  assign borrow_n = ~((count == '0) & ~dn_level);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter #(
  parameter int WIDTH       = 4,
  parameter int MODULUS     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic rst_n_s;
  logic up_level, up_rise;
  logic dn_level, dn_rise;

  dsc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dsc_strobe_edge #(.STAGES(SYNC_STAGES)) u_up_edge (
    .clk(clk), .rst_n(rst_n_s), .strobe_in(up_stb),
    .level_o(up_level), .rise_o(up_rise)
  );

  dsc_strobe_edge #(.STAGES(SYNC_STAGES)) u_dn_edge (
    .clk(clk), .rst_n(rst_n_s), .strobe_in(dn_stb),
    .level_o(dn_level), .rise_o(dn_rise)
  );

  dsc_count_core #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_core (
    .clk(clk), .rst_n(rst_n_s), .clear(clear), .load_n(load_n),
    .preset(preset), .up_rise(up_rise), .dn_rise(dn_rise),
    .count_o(count)
  );

  dsc_tc_flags #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_flags (
    .count(count), .up_level(up_level), .dn_level(dn_level),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_rise,
  input logic             dn_rise
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> (count == '0));

  // R7
  carry_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (count == TOP));

  // R8
  borrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (count == '0));

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !clear) |=> (clear || count == $past(preset)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !clear && (up_rise == dn_rise)) |=> (clear || $stable(count)));

  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !clear && up_rise && !dn_rise && count != TOP && count != '1)
      |=> (clear || count == $past(count) + ONE));
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset),
  .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
  .up_rise(up_rise), .dn_rise(dn_rise)
);

// File: tb/dual_strobe_counter_tb.sv
`timescale 1ns/1ps
module dual_strobe_counter_tb;
  logic clk = 1'b0;
  logic rst_n, up_s, dn_s, load_n, clear;
  logic [3:0] preset;
  logic [3:0] cnt_d, cnt_b;
  logic cy_d, bw_d, cy_b, bw_b;
  logic c_up, c_dn;
  logic [3:0] c0_cnt, c1_cnt;
  logic c0_cy, c0_bw, c1_cy, c1_bw;
  int checks = 0, errors = 0;
  int exp_d = 0, exp_b = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_strobe_counter #(.WIDTH(4), .MODULUS(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_stb(up_s), .dn_stb(dn_s), .load_n(load_n),
    .clear(clear), .preset(preset), .count(cnt_d), .carry_n(cy_d), .borrow_n(bw_d));

  dual_strobe_counter #(.WIDTH(4), .MODULUS(16)) u_bin (
    .clk(clk), .rst_n(rst_n), .up_stb(up_s), .dn_stb(dn_s), .load_n(load_n),
    .clear(clear), .preset(preset), .count(cnt_b), .carry_n(cy_b), .borrow_n(bw_b));

  dual_strobe_counter #(.WIDTH(4), .MODULUS(10)) u_c0 (
    .clk(clk), .rst_n(rst_n), .up_stb(c_up), .dn_stb(c_dn), .load_n(1'b1),
    .clear(clear), .preset(4'd0), .count(c0_cnt), .carry_n(c0_cy), .borrow_n(c0_bw));

  dual_strobe_counter #(.WIDTH(4), .MODULUS(10)) u_c1 (
    .clk(clk), .rst_n(rst_n), .up_stb(c0_cy), .dn_stb(c0_bw), .load_n(1'b1),
    .clear(clear), .preset(4'd0), .count(c1_cnt), .carry_n(c1_cy), .borrow_n(c1_bw));

  function automatic int m_up(input int v, input int m);
    return (v == m - 1 || v == 15) ? 0 : v + 1;
  endfunction

  function automatic int m_dn(input int v, input int m);
    return (v == 0) ? m - 1 : v - 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    check({tag, " dec count"}, cnt_d, exp_d);
    check({tag, " bin count"}, cnt_b, exp_b);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up_s = 1'b0; wait_neg(4);
    up_s = 1'b1; wait_neg(4);
    exp_d = m_up(exp_d, 10); exp_b = m_up(exp_b, 16);
  endtask

  task automatic pulse_dn();
    dn_s = 1'b0; wait_neg(4);
    dn_s = 1'b1; wait_neg(4);
    exp_d = m_dn(exp_d, 10); exp_b = m_dn(exp_b, 16);
  endtask

  task automatic do_load(input int v);
    preset = 4'(v); load_n = 1'b0; wait_neg(1);
    load_n = 1'b1; wait_neg(1);
    exp_d = v; exp_b = v;
  endtask

  task automatic t_reset();
    check("R1 dec count", cnt_d, 0);
    check("R1 bin count", cnt_b, 0);
    check("R1 carry_n", cy_d, 1);
    check("R1 borrow_n", bw_d, 1);
  endtask

  task automatic t_up();
    for (int i = 0; i < 5; i++) pulse_up();
    check_counts("R2 up x5");
  endtask

  task automatic t_load_carry();
    do_load(7);
    check_counts("R5 load 7");
    pulse_up(); pulse_up();
    check_counts("R2 up to 9");
    up_s = 1'b0; wait_neg(4);
    check("R7 dec carry low at 9", cy_d, 0);
    check("R7 bin carry high at 9", cy_b, 1);
    up_s = 1'b1; wait_neg(4);
    exp_d = m_up(exp_d, 10); exp_b = m_up(exp_b, 16);
    check_counts("R4 dec 9 wraps");
    check("R7 carry released", cy_d, 1);
  endtask

  task automatic t_over9();
    do_load(13);
    pulse_up();
    check_counts("R10 13 to 14");
    up_s = 1'b0; wait_neg(4);
    check("R10 dec carry high at 14", cy_d, 1);
    up_s = 1'b1; wait_neg(4);
    exp_d = m_up(exp_d, 10); exp_b = m_up(exp_b, 16);
    up_s = 1'b0; wait_neg(4);
    check("R10 dec carry high at 15", cy_d, 1);
    check("R7 bin carry low at 15", cy_b, 0);
    up_s = 1'b1; wait_neg(4);
    exp_d = m_up(exp_d, 10); exp_b = m_up(exp_b, 16);
    check_counts("R10 R4 15 wraps to 0");
  endtask

  task automatic t_down();
    dn_s = 1'b0; wait_neg(4);
    check("R8 dec borrow low at 0", bw_d, 0);
    check("R8 bin borrow low at 0", bw_b, 0);
    dn_s = 1'b1; wait_neg(4);
    exp_d = m_dn(exp_d, 10); exp_b = m_dn(exp_b, 16);
    check_counts("R4 down from 0");
    check("R8 borrow released", bw_d, 1);
    pulse_dn();
    check_counts("R3 down step");
  endtask

  task automatic t_both();
    up_s = 1'b0; dn_s = 1'b0; wait_neg(4);
    up_s = 1'b1; dn_s = 1'b1; wait_neg(4);
    check_counts("R9 same-cycle edges hold");
  endtask

  task automatic t_steady();
    up_s = 1'b0; wait_neg(12);
    check_counts("R2 steady low no change");
    up_s = 1'b1; wait_neg(4);
    exp_d = m_up(exp_d, 10); exp_b = m_up(exp_b, 16);
    check_counts("R2 rise after long low");
  endtask

  task automatic t_load_prio();
    preset = 4'd3; load_n = 1'b0;
    up_s = 1'b0; wait_neg(4);
    up_s = 1'b1; wait_neg(4);
    load_n = 1'b1; wait_neg(2);
    exp_d = 3; exp_b = 3;
    check_counts("R5 load beats up strobe");
  endtask

  task automatic t_clear();
    up_s = 1'b0; wait_neg(4);
    #2 clear = 1'b1; preset = 4'd5; load_n = 1'b0;
    #3;
    exp_d = 0; exp_b = 0;
    check_counts("R6 clear without clock");
    up_s = 1'b1; wait_neg(5);
    check_counts("R6 clear beats load and strobe");
    load_n = 1'b1; wait_neg(1);
    clear = 1'b0; wait_neg(2);
    check_counts("R6 after clear release");
  endtask

  task automatic t_cascade();
    for (int i = 0; i < 12; i++) begin
      c_up = 1'b0; wait_neg(8); c_up = 1'b1; wait_neg(8);
    end
    check("R11 low digit after 12 up", c0_cnt, 2);
    check("R11 high digit after 12 up", c1_cnt, 1);
    for (int i = 0; i < 3; i++) begin
      c_dn = 1'b0; wait_neg(8); c_dn = 1'b1; wait_neg(8);
    end
    check("R11 low digit after 3 down", c0_cnt, 9);
    check("R11 high digit after 3 down", c1_cnt, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; up_s = 1'b1; dn_s = 1'b1; load_n = 1'b1; clear = 1'b0;
    preset = 4'd0; c_up = 1'b1; c_dn = 1'b1;
    wait_neg(3);
    t_reset();
    rst_n = 1'b1; wait_neg(4);
    t_reset();
    t_up();
    t_load_carry();
    t_over9();
    t_down();
    t_both();
    t_steady();
    t_load_prio();
    t_clear();
    t_cascade();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule